// File: doc/BRIEF.md
# Two-Way Mailbox Register Pair

This block links a host CPU and a DSP core through two 32-bit mailboxes. The outbound mailbox carries mail from the DSP to the CPU. The inbound mailbox carries mail from the CPU to the DSP. Each mailbox is held as a 16-bit upper half and a 16-bit lower half. The top bit of the upper half is a pending flag that marks unread mail.

The sender writes the upper half first and the lower half last. The write to the lower half commits the message and raises the pending flag. The receiver reads the upper half, then the lower half. The read of the lower half consumes the message and drops the flag, so a complete 32-bit message moves through one lower-half access on each side.

When the CPU writes to the inbound mailbox, the DSP receives a one-cycle exception request at a fixed level. Both ports are single-cycle register ports: read data is combinational, and write effects and read side effects take place at the clock edge. Two side-effect-free peek outputs show each whole mailbox.

Top module: `dual_mailbox`

## Requirements
- R1: While rst_n is low, and after its release, all four halves read as zero. Both peek outputs are 0, and both exception outputs are 0.
- R2: A write to an upper half stores wdata[14:0] in bits 14:0 of that half and clears bit 15, the pending flag. The change is visible after the next rising edge.
- R3: A write to a lower half stores all 16 bits and sets the pending flag of the same mailbox at that edge.
- R4: A read of the receiver's lower half returns the stored value in the same cycle, and clears that mailbox's pending flag at the edge. The receiver's lower half is CPU offset 1 for the outbound mailbox and DSP address BASE+3 for the inbound mailbox.
- R5: A read of any upper half returns all 16 bits, including the flag, with no side effect. The same holds when a sender reads back its own lower half (DSP BASE+1, CPU offset 3).
- R6: The DSP window is four addresses starting at BASE (default 0xFC), ordered outbound-upper, outbound-lower, inbound-upper, inbound-lower. The 2-bit CPU offset uses the same order, 0 to 3.
- R7: A CPU write to offset 2 or 3 drives dsp_exc_req high for exactly the one cycle after that edge, with dsp_exc_level = EXC_LEVEL (default 7). At all other times dsp_exc_req is 0 and dsp_exc_level is 0. A DSP write never raises the request.
- R8: These writes change nothing: a DSP write to BASE+2, BASE+3 or any address outside the window, and a CPU write to offset 0 or 1. A DSP read outside the window returns 0.
- R9: out_peek and in_peek always show {upper, lower} of the outbound and inbound mailbox.
- R10: Suppose a lower-half write and the receiver's lower-half read hit the same mailbox in the same cycle. The read returns the old lower half, and after the edge the new data is stored with the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dsp_addr | input | AW | DSP register address |
| dsp_wr | input | 1 | DSP write strobe |
| dsp_rd | input | 1 | DSP read strobe (enables the read side effect) |
| dsp_wdata | input | DW | DSP write data |
| dsp_rdata | output | DW | DSP read data (combinational) |
| cpu_addr | input | 2 | CPU mailbox offset |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe (enables the read side effect) |
| cpu_wdata | input | DW | CPU write data |
| cpu_rdata | output | DW | CPU read data (combinational) |
| out_peek | output | 2*DW | Outbound mailbox {upper, lower} |
| in_peek | output | 2*DW | Inbound mailbox {upper, lower} |
| dsp_exc_req | output | 1 | One-cycle exception request to the DSP |
| dsp_exc_level | output | 3 | Exception level while the request is high, else 0 |

## Verification
The bench uses the default parameters: a 16-bit data path, an 8-bit DSP address and a window at 0xFC. At these values the DSP address space can be swept completely, so every address outside the window is shown to leave both mailboxes alone. Sixteen data patterns, including all-ones and walking bits, exercise the forced-zero flag bit on upper-half writes. The same-cycle write-and-consume cases are driven on both mailboxes, in both directions.

// File: rtl/dual_mailbox.sv
module dual_mailbox #(
  parameter int DW = 16,
  parameter int AW = 8,
  parameter logic [AW-1:0] BASE = 8'hFC,
  parameter int LVL_W = 3,
  parameter logic [LVL_W-1:0] EXC_LEVEL = 3'd7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   dsp_addr,
  input  logic            dsp_wr,
  input  logic            dsp_rd,
  input  logic [DW-1:0]   dsp_wdata,
  output logic [DW-1:0]   dsp_rdata,
  input  logic [1:0]      cpu_addr,
  input  logic            cpu_wr,
  input  logic            cpu_rd,
  input  logic [DW-1:0]   cpu_wdata,
  output logic [DW-1:0]   cpu_rdata,
  output logic [2*DW-1:0] out_peek,
  output logic [2*DW-1:0] in_peek,
  output logic            dsp_exc_req,
  output logic [LVL_W-1:0] dsp_exc_level
);
  localparam int FLAG = DW - 1;

  logic [DW-1:0] ob_hi, ob_lo, ib_hi, ib_lo;
  logic          exc_q;

  wire       dsp_in_win = (dsp_addr[AW-1:2] == BASE[AW-1:2]);
  wire [1:0] dsp_off    = dsp_addr[1:0];

  wire ob_wr_hi  = dsp_wr && dsp_in_win && dsp_off == 2'd0;
  wire ob_wr_lo  = dsp_wr && dsp_in_win && dsp_off == 2'd1;
  wire ob_take   = cpu_rd && cpu_addr == 2'd1;
  wire ib_wr_hi  = cpu_wr && cpu_addr == 2'd2;
  wire ib_wr_lo  = cpu_wr && cpu_addr == 2'd3;
  wire ib_take   = dsp_rd && dsp_in_win && dsp_off == 2'd3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ob_hi <= '0;
      ob_lo <= '0;
      ib_hi <= '0;
      ib_lo <= '0;
      exc_q <= 1'b0;
    end else begin
      if (ob_wr_hi)      ob_hi <= {1'b0, dsp_wdata[FLAG-1:0]};
      else if (ob_wr_lo) ob_hi[FLAG] <= 1'b1;
      else if (ob_take)  ob_hi[FLAG] <= 1'b0;
      if (ob_wr_lo)      ob_lo <= dsp_wdata;

      if (ib_wr_hi)      ib_hi <= {1'b0, cpu_wdata[FLAG-1:0]};
      else if (ib_wr_lo) ib_hi[FLAG] <= 1'b1;
      else if (ib_take)  ib_hi[FLAG] <= 1'b0;
      if (ib_wr_lo)      ib_lo <= cpu_wdata;

      exc_q <= ib_wr_hi || ib_wr_lo;
    end
  end

  always_comb begin
    case (cpu_addr)
      2'd0:    cpu_rdata = ob_hi;
      2'd1:    cpu_rdata = ob_lo;
      2'd2:    cpu_rdata = ib_hi;
      default: cpu_rdata = ib_lo;
    endcase
    dsp_rdata = '0;
    if (dsp_in_win) begin
      case (dsp_off)
        2'd0:    dsp_rdata = ob_hi;
        2'd1:    dsp_rdata = ob_lo;
        2'd2:    dsp_rdata = ib_hi;
        default: dsp_rdata = ib_lo;
      endcase
    end
  end

  assign out_peek      = {ob_hi, ob_lo};
  assign in_peek       = {ib_hi, ib_lo};
  assign dsp_exc_req   = exc_q;
  assign dsp_exc_level = exc_q ? EXC_LEVEL : '0;

  AST_OB_HI_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_wr && dsp_addr == BASE) |=> (out_peek[2*DW-1] == 1'b0 &&
      out_peek[2*DW-2:DW] == $past(dsp_wdata[DW-2:0]))); // R2
  AST_IB_LO_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == 2'd3) |=> (in_peek[2*DW-1] && in_peek[DW-1:0] == $past(cpu_wdata))); // R3
  AST_OB_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_addr == 2'd1 && !(dsp_wr && dsp_addr == BASE + 1'b1)) |=> !out_peek[2*DW-1]); // R4
  AST_EXC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[1]) |=> (dsp_exc_req && dsp_exc_level == EXC_LEVEL)); // R7
  AST_EXC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wr && cpu_addr[1]) |=> (!dsp_exc_req && dsp_exc_level == '0)); // R7
  AST_IGNORED_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_wr && !(dsp_addr == BASE || dsp_addr == BASE + 1'b1) && !cpu_wr && !cpu_rd && !dsp_rd)
      |=> ($stable(out_peek) && $stable(in_peek))); // R8
  AST_BOTH_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_wr && dsp_addr == BASE + 1'b1 && cpu_rd && cpu_addr == 2'd1) |=> out_peek[2*DW-1]); // R10
endmodule

// File: tb/test_dual_mailbox.sv
`timescale 1ns/1ps
module test_dual_mailbox;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  dsp_addr = '0;
  logic        dsp_wr = 1'b0, dsp_rd = 1'b0;
  logic [15:0] dsp_wdata = '0;
  logic [15:0] dsp_rdata;
  logic [1:0]  cpu_addr = '0;
  logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [15:0] cpu_wdata = '0;
  logic [15:0] cpu_rdata;
  logic [31:0] out_peek, in_peek;
  logic        dsp_exc_req;
  logic [2:0]  dsp_exc_level;

  int checks = 0;
  int fails = 0;
  logic [31:0] e_out = '0, e_in = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dual_mailbox i_dual_mailbox (
    .clk(clk), .rst_n(rst_n),
    .dsp_addr(dsp_addr), .dsp_wr(dsp_wr), .dsp_rd(dsp_rd),
    .dsp_wdata(dsp_wdata), .dsp_rdata(dsp_rdata),
    .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .out_peek(out_peek), .in_peek(in_peek),
    .dsp_exc_req(dsp_exc_req), .dsp_exc_level(dsp_exc_level)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic dw, input logic dr, input logic [7:0] da, input logic [15:0] dd,
                       input logic cw, input logic cr, input logic [1:0] ca, input logic [15:0] cd);
    @(negedge clk);
    dsp_wr = dw; dsp_rd = dr; dsp_addr = da; dsp_wdata = dd;
    cpu_wr = cw; cpu_rd = cr; cpu_addr = ca; cpu_wdata = cd;
    #1;
  endtask

  task automatic idle();
    drive(0, 0, 8'h00, 16'h0, 0, 0, 2'd0, 16'h0);
  endtask

  task automatic chk_state(input string req);
    chk({req, " out_peek"}, out_peek, e_out);
    chk({req, " in_peek"}, in_peek, e_in);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset out", out_peek, 32'h0);
    chk("R1 reset in", in_peek, 32'h0);
    chk("R1 reset exc", {29'h0, dsp_exc_level}, 32'h0);
    rst_n = 1'b1;
    idle();
    chk_state("R1 after release");
    chk("R1 exc idle", {31'h0, dsp_exc_req}, 32'h0);

    for (int i = 0; i < 16; i++) begin
      logic [15:0] vh, vl;
      vh = (i == 0) ? 16'hFFFF : (16'h1 << i) ^ 16'h8000;
      vl = 16'hA5A5 ^ (16'(i) * 16'h1357);
      // outbound: DSP sends (R2, R3), CPU receives (R4, R5, R6)
      drive(1, 0, 8'hFC, vh, 0, 0, 2'd0, 16'h0);
      e_out[31:16] = {1'b0, vh[14:0]};
      idle();
      chk_state("R2 upper write");
      chk("R7 no exc on dsp write", {31'h0, dsp_exc_req}, 32'h0);
      drive(1, 0, 8'hFD, vl, 0, 0, 2'd0, 16'h0);
      e_out[15:0] = vl; e_out[31] = 1'b1;
      idle();
      chk_state("R3 lower write sets flag");
      chk("R7 no exc on dsp write", {31'h0, dsp_exc_req}, 32'h0);
      drive(0, 0, 8'h00, 16'h0, 0, 1, 2'd0, 16'h0);
      chk("R5 R6 cpu reads upper", {16'h0, cpu_rdata}, {16'h0, e_out[31:16]});
      idle();
      chk_state("R5 upper read no effect");
      drive(0, 1, 8'hFD, 16'h0, 0, 0, 2'd0, 16'h0);
      chk("R6 dsp reads own lower", {16'h0, dsp_rdata}, {16'h0, vl});
      idle();
      chk_state("R5 sender lower read no effect");
      drive(0, 0, 8'h00, 16'h0, 0, 1, 2'd1, 16'h0);
      chk("R4 cpu reads lower", {16'h0, cpu_rdata}, {16'h0, vl});
      e_out[31] = 1'b0;
      idle();
      chk_state("R4 lower read clears flag");
      chk("R9 peek matches", out_peek, {1'b0, vh[14:0], vl});

      // inbound: CPU sends with exception (R7), DSP receives
      drive(0, 0, 8'h00, 16'h0, 1, 0, 2'd2, ~vh);
      e_in[31:16] = {1'b0, ~vh[14:0]};
      idle();
      chk_state("R2 cpu upper write");
      chk("R7 exc pulse", {28'h0, dsp_exc_req, dsp_exc_level}, {28'h0, 1'b1, 3'd7});
      idle();
      chk("R7 exc one cycle", {28'h0, dsp_exc_req, dsp_exc_level}, 32'h0);
      drive(0, 0, 8'h00, 16'h0, 1, 0, 2'd3, ~vl);
      e_in[15:0] = ~vl; e_in[31] = 1'b1;
      idle();
      chk_state("R3 cpu lower write");
      chk("R7 exc pulse lower", {28'h0, dsp_exc_req, dsp_exc_level}, {28'h0, 1'b1, 3'd7});
      drive(0, 1, 8'hFE, 16'h0, 0, 1, 2'd3, 16'h0);
      chk("R5 R6 dsp reads inbound upper", {16'h0, dsp_rdata}, {16'h0, e_in[31:16]});
      chk("R5 cpu reads own lower", {16'h0, cpu_rdata}, {16'h0, ~vl});
      idle();
      chk_state("R5 no effect inbound");
      drive(0, 1, 8'hFF, 16'h0, 0, 0, 2'd0, 16'h0);
      chk("R4 dsp reads inbound lower", {16'h0, dsp_rdata}, {16'h0, ~vl});
      e_in[31] = 1'b0;
      idle();
      chk_state("R4 inbound flag cleared");
    end

    // R8: full DSP address sweep of writes, reads outside window
    for (int a = 0; a < 256; a++) begin
      if (a == 8'hFC || a == 8'hFD) continue;
      drive(1, 0, 8'(a), 16'hFFFF, 0, 0, 2'd0, 16'h0);
      idle();
      chk_state("R8 ignored dsp write");
      if (a < 8'hFC) begin
        drive(0, 1, 8'(a), 16'h0, 0, 0, 2'd0, 16'h0);
        chk("R8 outside read zero", {16'h0, dsp_rdata}, 32'h0);
      end
    end
    for (int c = 0; c < 2; c++) begin
      drive(0, 0, 8'h00, 16'h0, 1, 0, 2'(c), 16'hFFFF);
      idle();
      chk_state("R8 ignored cpu write");
      chk("R8 no exc", {31'h0, dsp_exc_req}, 32'h0);
    end

    // R10: same-cycle commit and consume, both mailboxes
    drive(1, 0, 8'hFD, 16'h1111, 0, 0, 2'd0, 16'h0);
    e_out[15:0] = 16'h1111; e_out[31] = 1'b1;
    drive(1, 0, 8'hFD, 16'h2222, 0, 1, 2'd1, 16'h0);
    chk("R10 cpu read sees old", {16'h0, cpu_rdata}, 32'h1111);
    e_out[15:0] = 16'h2222;
    idle();
    chk_state("R10 outbound write wins");
    drive(0, 0, 8'h00, 16'h0, 1, 0, 2'd3, 16'h3333);
    e_in[15:0] = 16'h3333; e_in[31] = 1'b1;
    drive(0, 1, 8'hFF, 16'h0, 1, 0, 2'd3, 16'h4444);
    chk("R10 dsp read sees old", {16'h0, dsp_rdata}, 32'h3333);
    e_in[15:0] = 16'h4444;
    idle();
    chk_state("R10 inbound write wins");

    // R1: reset mid-operation clears pending flags
    rst_n = 1'b0;
    #1;
    chk("R1 async reset out", out_peek, 32'h0);
    chk("R1 async reset in", in_peek, 32'h0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule